// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is a small accumulator processor core that runs each instruction as a chain of machine cycles. The four kinds of machine cycle are fetch, indirect (effective address), execute and interrupt. The core keeps a program counter, an instruction register, an accumulator and a stack pointer. All memory traffic passes through an address register and a data register. The memory is a single-port synchronous RAM outside the core. Each machine cycle lasts exactly four clock beats. Beat 0 loads the address register. Beat 1 drives the read or write strobe. Beat 2 captures read data. Beat 3 performs the register transfer and picks the next machine cycle.

The memory port is not a stream, so it has no valid/ready handshake. The memory must return read data on the clock beat after the read strobe, and it must accept a write on the beat that carries the write strobe. Back-pressure cannot occur: the core never waits, and the memory may never stall. The remaining pins are plain signals:
- a level interrupt request;
- a fixed handler start address;
- a one-hot flag per machine cycle;
- a one-beat pulse when an instruction or an interrupt entry completes;
- the architectural PC, AC and SP, which can be observed after each step.

Instruction word: bits 15:12 hold the opcode, bit 11 is the indirect flag and bits 10:0 are the address field.

Opcodes:

| Code | Mnemonic | Effect |
|------|----------|--------|
| 0 | NOP | No operation |
| 1 | LOAD | AC gets the memory word |
| 2 | ADD | AC gets AC plus the memory word |
| 3 | STORE | The memory word gets AC |
| 4 | JMP | PC gets the address |
| 5 | EI | Enable interrupts |
| 6 | RETI | Pop PC and enable interrupts |

Codes 7 to 15 behave as NOP.

Top module: `mcs_core`

## Requirements
- R1: While reset is held and directly after it, PC=0, AC=0, SP=2048 (one above the top address 2047), interrupts are disabled, the cycle flags are 4'b0001 (bit0 fetch, bit1 indirect, bit2 execute, bit3 interrupt), and both memory strobes are low.
- R2: A fetch reads the word at PC into the instruction register and then increments PC by one. Every machine cycle spans four beats: the strobe is on beat 1 and the read data is captured on beat 2.
- R3: The number of machine cycles depends on the instruction. NOP, EI and codes 7 to 15 use fetch only. LOAD, ADD, STORE and JMP with bit 11 clear, and RETI, use fetch and execute. LOAD, ADD, STORE and JMP with bit 11 set use fetch, indirect and execute. Bit 11 is ignored on the other opcodes.
- R4: An indirect cycle reads the word at the address field and replaces the address field with the low 11 bits of that word. This new value is the effective address used by execute.
- R5: LOAD sets AC to mem[ea]. ADD sets AC to (AC + mem[ea]) mod 2^16. STORE writes AC to mem[ea].
- R6: JMP sets PC to the effective address.
- R7: Exactly one cycle flag is set in every clock cycle.
- R8: The interrupt request is sampled only in the last beat of an instruction. An interrupt cycle follows only if the request is high and interrupts are enabled, counting an enable made by that same instruction. Otherwise the request has no effect.
- R9: An interrupt cycle first decrements SP. It then writes the incremented PC, zero-extended, to mem[SP]. Finally it loads PC with the handler address.
- R10: Taking an interrupt disables interrupts, so a request held high is not taken again. EI re-enables them. RETI loads PC from the low 11 bits of mem[SP], increments SP and re-enables interrupts.
- R11: Opcodes 7 to 15 change no register other than PC and write no memory.
- R12: The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_addr | output | 11 | Memory address (address register) |
| mem_rd | output | 1 | Read strobe; data expected on the next beat |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (data register) |
| mem_rdata | input | 16 | Read data from memory |
| irq | input | 1 | Level interrupt request |
| isr_addr | input | 11 | Interrupt handler start address |
| cyc_flags | output | 4 | One-hot machine cycle flags: fetch, indirect, execute, interrupt |
| step_done | output | 1 | High in the last beat of an instruction or an interrupt entry |
| pc_o | output | 11 | Program counter |
| ac_o | output | 16 | Accumulator |
| sp_o | output | 12 | Stack pointer |

## Verification
PC, AC, SP and memory contents for a step are due one clock edge after the beat in which `step_done` is high. The bench samples on falling edges, waits for that pulse, and compares one falling edge later against its own instruction-level model. For each step, the bench counts the falling edges spent under each cycle flag and expects exactly four per machine cycle that the requirements call for. The interrupt request changes only after a step's decision edge has passed, so the model knows the sampled value exactly.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int DW    = 16;
  localparam int OPW   = 4;
  localparam int AW    = DW - OPW - 1;
  localparam int NCYC  = 4;
  localparam int BEATS = 4;

  localparam int C_FET = 0;
  localparam int C_IND = 1;
  localparam int C_EXE = 2;
  localparam int C_INT = 3;

  localparam logic [OPW-1:0] OP_NOP   = 4'h0;
  localparam logic [OPW-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPW-1:0] OP_ADD   = 4'h2;
  localparam logic [OPW-1:0] OP_STORE = 4'h3;
  localparam logic [OPW-1:0] OP_JMP   = 4'h4;
  localparam logic [OPW-1:0] OP_EI    = 4'h5;
  localparam logic [OPW-1:0] OP_RETI  = 4'h6;
endpackage

// File: rtl/mcs_decode.sv
module mcs_decode #(
  parameter int DW  = mcs_pkg::DW,
  parameter int OPW = mcs_pkg::OPW,
  parameter int AW  = mcs_pkg::AW
) (
  input  logic [DW-1:0] iw,
  output logic          need_ind,
  output logic          need_exe,
  output logic          is_load,
  output logic          is_add,
  output logic          is_store,
  output logic          is_jmp,
  output logic          is_ei,
  output logic          is_reti
);
  import mcs_pkg::*;

  logic [OPW-1:0] opc;
  logic           ind_bit;
  logic           uses_addr;
  logic [AW-1:0]  unused_addr;

  assign opc         = iw[DW-1 -: OPW];
  assign ind_bit     = iw[AW];
  assign unused_addr = iw[AW-1:0];

  always_comb begin
    is_load  = (opc == OP_LOAD);
    is_add   = (opc == OP_ADD);
    is_store = (opc == OP_STORE);
    is_jmp   = (opc == OP_JMP);
    is_ei    = (opc == OP_EI);
    is_reti  = (opc == OP_RETI);
  end

  // R3: address-using opcodes may take the indirect path; RETI needs execute
  assign uses_addr = is_load | is_add | is_store | is_jmp;
  assign need_ind  = uses_addr & ind_bit;
  assign need_exe  = uses_addr | is_reti;
endmodule

// File: rtl/mcs_timing.sv
module mcs_timing #(
  parameter int NCYC  = mcs_pkg::NCYC,
  parameter int BEATS = mcs_pkg::BEATS,
  localparam int BW   = $clog2(BEATS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            need_ind,
  input  logic            need_exe,
  input  logic            take_int,
  output logic [NCYC-1:0] flags,
  output logic [BW-1:0]   beat,
  output logic            step_done
);
  import mcs_pkg::*;

  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic            last;
  logic            end_insn;
  logic [NCYC-1:0] nxt;

  assign last      = (beat == LAST);
  assign end_insn  = last & ((flags[C_FET] & ~need_ind & ~need_exe) | flags[C_EXE]);
  assign step_done = end_insn | (last & flags[C_INT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat <= '0;
    else        beat <= last ? '0 : beat + BW'(1);
  end

  always_comb begin
    nxt = '0;
    if (!last) begin
      nxt = flags;
    end else if (flags[C_FET]) begin
      if (need_ind)      nxt[C_IND] = 1'b1;
      else if (need_exe) nxt[C_EXE] = 1'b1;
      else if (take_int) nxt[C_INT] = 1'b1;
      else               nxt[C_FET] = 1'b1;
    end else if (flags[C_IND]) begin
      nxt[C_EXE] = 1'b1;
    end else if (flags[C_EXE]) begin
      if (take_int) nxt[C_INT] = 1'b1;
      else          nxt[C_FET] = 1'b1;
    end else begin
      nxt[C_FET] = 1'b1;
    end
  end

  for (genvar g = 0; g < NCYC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= (g == C_FET);
      else        flags[g] <= nxt[g];
    end
  end

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) == 1);

  p_cycle_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat != LAST) |=> $stable(flags));

  p_ind_then_exe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[C_IND] && last) |=> flags[C_EXE]);
endmodule

// File: rtl/mcs_datapath.sv
module mcs_datapath #(
  parameter int DW    = mcs_pkg::DW,
  parameter int AW    = mcs_pkg::AW,
  parameter int NCYC  = mcs_pkg::NCYC,
  parameter int BEATS = mcs_pkg::BEATS,
  localparam int BW   = $clog2(BEATS),
  localparam int SPW  = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCYC-1:0] flags,
  input  logic [BW-1:0]   beat,
  input  logic            is_load,
  input  logic            is_add,
  input  logic            is_store,
  input  logic            is_jmp,
  input  logic            is_ei,
  input  logic            is_reti,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            irq,
  input  logic [AW-1:0]   isr_addr,
  output logic [AW-1:0]   mar,
  output logic [DW-1:0]   mdr,
  output logic [DW-1:0]   ir,
  output logic [AW-1:0]   pc,
  output logic [DW-1:0]   ac,
  output logic [SPW-1:0]  sp,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            take_int
);
  import mcs_pkg::*;

  localparam logic [SPW-1:0] SP_RST = {1'b1, {AW{1'b0}}};
  localparam logic [BW-1:0]  B_ADR  = BW'(0);
  localparam logic [BW-1:0]  B_STB  = BW'(1);
  localparam logic [BW-1:0]  B_CAP  = BW'(2);
  localparam logic [BW-1:0]  B_XFR  = BW'(BEATS - 1);

  logic           ie;
  logic           rd_cyc;
  logic           wr_cyc;
  logic [SPW-1:0] sp_dec;
  logic [DW-1:0]  pc_ext;

  assign sp_dec = sp - SPW'(1);
  assign pc_ext = {{(DW-AW){1'b0}}, pc};

  assign rd_cyc = flags[C_FET] | flags[C_IND] | (flags[C_EXE] & (is_load | is_add | is_reti));
  assign wr_cyc = flags[C_INT] | (flags[C_EXE] & is_store);
  assign mem_rd = rd_cyc & (beat == B_STB);
  assign mem_wr = wr_cyc & (beat == B_STB);

  // R8: enable as it stands after the ending instruction
  assign take_int = irq & (ie | (flags[C_FET] & is_ei) | (flags[C_EXE] & is_reti));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      ir  <= '0;
      ac  <= '0;
      sp  <= SP_RST;
      mar <= '0;
      mdr <= '0;
      ie  <= 1'b0;
    end else if (beat == B_ADR) begin
      if (flags[C_FET]) mar <= pc;
      if (flags[C_IND]) mar <= ir[AW-1:0];
      if (flags[C_EXE]) begin
        mar <= is_reti ? sp[AW-1:0] : ir[AW-1:0];
        if (is_store) mdr <= ac;
      end
      if (flags[C_INT]) begin
        sp  <= sp_dec;
        mar <= sp_dec[AW-1:0];
        mdr <= pc_ext;
      end
    end else if (beat == B_CAP) begin
      if (rd_cyc) mdr <= mem_rdata;
    end else if (beat == B_XFR) begin
      if (flags[C_FET]) begin
        ir <= mdr;
        pc <= pc + AW'(1);
        if (is_ei) ie <= 1'b1;
      end
      if (flags[C_IND]) ir[AW-1:0] <= mdr[AW-1:0];
      if (flags[C_EXE]) begin
        if (is_load) ac <= mdr;
        if (is_add)  ac <= ac + mdr;
        if (is_jmp)  pc <= ir[AW-1:0];
        if (is_reti) begin
          pc <= mdr[AW-1:0];
          sp <= sp + SPW'(1);
          ie <= 1'b1;
        end
      end
      if (flags[C_INT]) begin
        pc <= isr_addr;
        ie <= 1'b0;
      end
    end
  end

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_pc_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[C_FET] && beat == B_XFR) |=> pc == $past(pc) + AW'(1));

  p_sp_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[C_INT] && beat == B_ADR) |=> sp == $past(sp) - SPW'(1));

  p_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[C_INT] && beat == B_STB) |-> (mem_wr && mar == sp[AW-1:0] && mdr == pc_ext));

  p_ie_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[C_INT] && beat == B_XFR) |=> !ie);
endmodule

// File: rtl/mcs_core.sv
module mcs_core #(
  parameter int DW    = mcs_pkg::DW,
  parameter int OPW   = mcs_pkg::OPW,
  parameter int NCYC  = mcs_pkg::NCYC,
  parameter int BEATS = mcs_pkg::BEATS,
  localparam int AW   = DW - OPW - 1,
  localparam int SPW  = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            irq,
  input  logic [AW-1:0]   isr_addr,
  output logic [NCYC-1:0] cyc_flags,
  output logic            step_done,
  output logic [AW-1:0]   pc_o,
  output logic [DW-1:0]   ac_o,
  output logic [SPW-1:0]  sp_o
);
  import mcs_pkg::*;

  localparam int BW = $clog2(BEATS);

  logic [NCYC-1:0] flags;
  logic [BW-1:0]   beat;
  logic [DW-1:0]   mdr, ir, iw;
  logic [AW-1:0]   mar;
  logic need_ind, need_exe, take_int;
  logic is_load, is_add, is_store, is_jmp, is_ei, is_reti;

  // during fetch the word is still in the data register
  assign iw = flags[C_FET] ? mdr : ir;

  mcs_decode #(.DW(DW), .OPW(OPW), .AW(AW)) u_dec (
    .iw(iw), .need_ind(need_ind), .need_exe(need_exe),
    .is_load(is_load), .is_add(is_add), .is_store(is_store),
    .is_jmp(is_jmp), .is_ei(is_ei), .is_reti(is_reti)
  );

  mcs_timing #(.NCYC(NCYC), .BEATS(BEATS)) u_tim (
    .clk(clk), .rst_n(rst_n), .need_ind(need_ind), .need_exe(need_exe),
    .take_int(take_int), .flags(flags), .beat(beat), .step_done(step_done)
  );

  mcs_datapath #(.DW(DW), .AW(AW), .NCYC(NCYC), .BEATS(BEATS)) u_dp (
    .clk(clk), .rst_n(rst_n), .flags(flags), .beat(beat),
    .is_load(is_load), .is_add(is_add), .is_store(is_store),
    .is_jmp(is_jmp), .is_ei(is_ei), .is_reti(is_reti),
    .mem_rdata(mem_rdata), .irq(irq), .isr_addr(isr_addr),
    .mar(mar), .mdr(mdr), .ir(ir), .pc(pc_o), .ac(ac_o), .sp(sp_o),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .take_int(take_int)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign cyc_flags = flags;

  p_int_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[C_INT]) |-> $past(irq));
endmodule

// File: tb/test_mcs_core.sv
module test_mcs_core;
  localparam int MW = 2048;
  localparam logic [10:0] ISR = 11'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq = 1'b0;
  logic [3:0]  cyc_flags;
  logic        step_done;
  logic [10:0] pc_o;
  logic [15:0] ac_o;
  logic [11:0] sp_o;

  always #5 clk = ~clk;

  mcs_core i_mcs_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq), .isr_addr(ISR), .cyc_flags(cyc_flags), .step_done(step_done),
    .pc_o(pc_o), .ac_o(ac_o), .sp_o(sp_o)
  );

  logic [15:0] mem [0:MW-1];
  logic [15:0] rm  [0:MW-1];

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int checks = 0;
  int errors = 0;
  logic [10:0] m_pc;
  logic [15:0] m_ac;
  logic [11:0] m_sp;
  logic        m_ie, m_int_next;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic ind, input logic [10:0] a);
    return {op, ind, a};
  endfunction

  task automatic put(input logic [10:0] a, input logic [15:0] w);
    mem[a] = w;
    rm[a]  = w;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) begin
      mem[i] = '0;
      rm[i]  = '0;
    end
  endtask

  task automatic start();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_pc = '0; m_ac = '0; m_sp = 12'd2048; m_ie = 1'b0; m_int_next = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic model_step(output int ef, output int ei, output int ee, output int en);
    logic [15:0] w;
    logic [3:0]  op;
    logic [10:0] a;
    logic        uses;
    ef = 0; ei = 0; ee = 0; en = 0;
    if (m_int_next) begin
      m_sp = m_sp - 12'd1;
      rm[m_sp[10:0]] = {5'b0, m_pc};
      m_pc = ISR;
      m_ie = 1'b0;
      m_int_next = 1'b0;
      en = 4;
    end else begin
      w = rm[m_pc];
      m_pc = m_pc + 11'd1;
      op = w[15:12];
      a = w[10:0];
      uses = (op >= 4'd1) && (op <= 4'd4);
      ef = 4;
      if (uses && w[11]) begin
        a = rm[a][10:0];
        ei = 4;
      end
      if (uses || op == 4'd6) ee = 4;
      case (op)
        4'd1: m_ac = rm[a];
        4'd2: m_ac = m_ac + rm[a];
        4'd3: rm[a] = m_ac;
        4'd4: m_pc = a;
        4'd5: m_ie = 1'b1;
        4'd6: begin
          m_pc = rm[m_sp[10:0]][10:0];
          m_sp = m_sp + 12'd1;
          m_ie = 1'b1;
        end
        default: ;
      endcase
      m_int_next = m_ie && irq;
    end
  endtask

  // positioned at the falling edge of beat 0 of a step
  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int tf, ti, te, tn, ef, ei, ee, en;
      bit done;
      tf = 0; ti = 0; te = 0; tn = 0; done = 0;
      while (!done) begin
        if (cyc_flags[0]) tf++;
        if (cyc_flags[1]) ti++;
        if (cyc_flags[2]) te++;
        if (cyc_flags[3]) tn++;
        if (step_done) done = 1;
        else @(negedge clk);
      end
      model_step(ef, ei, ee, en);
      @(negedge clk);
      chk(pc_o == m_pc, tag, "pc", 32'(pc_o), 32'(m_pc));
      chk(ac_o == m_ac, tag, "ac", 32'(ac_o), 32'(m_ac));
      chk(sp_o == m_sp, tag, "sp", 32'(sp_o), 32'(m_sp));
      chk({tf[7:0], ti[7:0], te[7:0], tn[7:0]} == {ef[7:0], ei[7:0], ee[7:0], en[7:0]},
          tag, "R3 cycle beats f/i/e/n",
          {tf[7:0], ti[7:0], te[7:0], tn[7:0]}, {ef[7:0], ei[7:0], ee[7:0], en[7:0]});
    end
  endtask

  task automatic mem_cmp(input string tag);
    int bad;
    int first;
    bad = 0; first = -1;
    for (int i = 0; i < MW; i++)
      if (mem[i] !== rm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, tag, "memory", 0, 0);
    else chk(1'b0, tag, "memory word", 32'(mem[first]), 32'(rm[first]));
  endtask

  task automatic t_reset();
    clear_mem();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pc_o == 11'd0 && ac_o == 16'd0, "R1", "pc/ac in reset", {5'b0, pc_o, ac_o}, 0);
    chk(sp_o == 12'd2048, "R1", "sp in reset", 32'(sp_o), 32'd2048);
    chk(cyc_flags == 4'b0001, "R1", "flags in reset", 32'(cyc_flags), 1);
    chk(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
  endtask

  task automatic t_direct();
    clear_mem();
    put(0, enc(4'h1, 0, 11'd100));
    put(1, enc(4'h2, 0, 11'd101));
    put(2, enc(4'h3, 0, 11'd102));
    put(3, enc(4'h0, 0, 11'd0));
    put(4, enc(4'h4, 0, 11'd8));
    put(5, enc(4'h1, 0, 11'd101));
    put(8, enc(4'h2, 0, 11'd100));
    put(9, enc(4'h3, 0, 11'd103));
    put(10, enc(4'hF, 1, 11'd104));  // R11 unused code, no write to 104
    put(11, enc(4'h9, 0, 11'd105));
    put(100, 16'h1234);
    put(101, 16'h0101);
    start();
    chk(pc_o == 0 && sp_o == 12'd2048 && cyc_flags == 4'b0001, "R1", "state after reset",
        {9'b0, pc_o, sp_o}, {20'b0, 12'd2048});
    run(9, "R2_R5_R6_R11");
    mem_cmp("R5");
    chk(mem[104] == 16'h0 && mem[105] == 16'h0, "R11", "unused opcode wrote memory",
        {mem[104], mem[105]}, 0);
  endtask

  task automatic t_indirect();
    clear_mem();
    put(0, enc(4'h1, 1, 11'd200));
    put(1, enc(4'h2, 1, 11'd201));
    put(2, enc(4'h3, 1, 11'd202));
    put(3, enc(4'h4, 1, 11'd203));
    put(20, enc(4'h0, 1, 11'd7));   // bit 11 ignored on NOP
    put(21, enc(4'h3, 0, 11'd400));
    put(200, 16'hF12C);              // effective address = low 11 bits = 0x12C
    put(201, 16'd301);
    put(202, 16'd302);
    put(203, 16'd20);
    put(11'h12C, 16'h0005);
    put(301, 16'h0007);
    start();
    run(6, "R4_R3");
    mem_cmp("R4");
    chk(mem[302] == 16'h000C, "R4", "indirect store", 32'(mem[302]), 32'h000C);
  endtask

  task automatic t_wrap();
    clear_mem();
    put(0, enc(4'h1, 0, 11'd100));
    put(1, enc(4'h2, 0, 11'd101));
    put(2, enc(4'h3, 0, 11'd102));
    put(100, 16'hFFFF);
    put(101, 16'h0002);
    start();
    run(3, "R5");
    chk(mem[102] == 16'h0001, "R5", "add wraps mod 2^16", 32'(mem[102]), 1);
  endtask

  task automatic t_masked();
    clear_mem();
    put(1, enc(4'h1, 0, 11'd50));
    put(50, 16'hABCD);
    irq = 1'b1;
    start();
    run(5, "R8");
    chk(sp_o == 12'd2048 && pc_o == 11'd5, "R8", "disabled request ignored",
        {9'b0, pc_o, sp_o}, {9'b0, 11'd5, 12'd2048});
    irq = 1'b0;
  endtask

  task automatic t_take();
    clear_mem();
    put(0, enc(4'h5, 0, 0));
    put(2, enc(4'h1, 0, 11'd60));
    put(60, 16'hBEEF);
    put(50, 16'h0077);
    put(ISR, enc(4'h1, 0, 11'd50));
    put(ISR + 1, enc(4'h3, 0, 11'd51));
    put(ISR + 2, enc(4'h6, 0, 0));
    irq = 1'b1;
    start();
    run(2, "R8_R9");
    chk(pc_o == ISR && sp_o == 12'd2047, "R9", "handler entry",
        {9'b0, pc_o, sp_o}, {9'b0, ISR, 12'd2047});
    chk(mem[2047] == 16'd1, "R9", "pushed return address", 32'(mem[2047]), 1);
    irq = 1'b0;
    run(5, "R10");
    mem_cmp("R9");
  endtask

  task automatic t_hold();
    clear_mem();
    put(0, enc(4'h5, 0, 0));
    put(ISR + 2, enc(4'h6, 0, 0));
    irq = 1'b1;
    start();
    run(4, "R10");  // EI, interrupt, NOP, NOP in handler: not retaken
    chk(pc_o == ISR + 11'd2 && sp_o == 12'd2047, "R10", "held request not retaken",
        {9'b0, pc_o, sp_o}, {9'b0, ISR + 11'd2, 12'd2047});
    run(3, "R10");  // RETI re-enables, taken again, handler NOP
    irq = 1'b0;
    run(3, "R10");  // NOP, RETI, NOP
    mem_cmp("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_indirect();
    t_wrap();
    t_masked();
    t_take();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule